// File: doc/BRIEF.md
# Day-Time Counter With Alarm

This block is the time-keeping core of a real-time clock. A slow clock divided down elsewhere provides a one-second strobe and a half-second strobe. Each counted second advances a single 32-bit word that holds seconds, minutes, hours and a day number as separate fields. Carries move up through the fields, and each carry raises a boundary flag. The hour, minute and second fields are compared with an alarm word. When they match, an alarm flag is raised and can drive an interrupt and a wake-up line.

Software reaches the block through a single-cycle register port. Writes take effect at the next clock edge. Read data is combinational from the address. Status flags are cleared by writing ones to them. The trim register only holds a value for the divider outside this block.

Top module: `rtc_daytime_core`

## Requirements
- R1: After reset, the counter, alarm, control, status and trim registers read zero, and irq_periodic, irq_alarm and wake_out are low.
- R2: The counter at offset 0x10 holds seconds in [5:0], minutes in [11:6], hours in [16:12] and days in [31:17]. A tick_sec pulse adds one second only while control bit 0 is set; when that bit is clear, ticks change neither the counter nor the status register.
- R3: Seconds and minutes wrap from 59 to 0, and hours wrap from 23 to 0. Each wrap carries into the next field. The day field wraps from 32767 to 0.
- R4: Status flags are set as follows: bit 6 on every counted second; bit 5 when the minute field advances; bit 4 when the hour field advances; bit 3 when the day field advances; bit 7 on a tick_half pulse while control bit 0 is set.
- R5: Status bit 2 is set when a counted second makes counter bits [16:0] equal alarm bits [16:0]. The day field takes no part in the match.
- R6: The status register at offset 0x1C clears a flag when a 1 is written to its bit. Writing 0 leaves the flag unchanged. When a flag is set and cleared in the same cycle, it stays set.
- R7: irq_periodic is high when any status flag in bits [7:3] is set and its control enable at the same bit is set. irq_alarm is status bit 2 AND control bit 2. wake_out is status bit 2 AND control bit 1.
- R8: Offset 0x00 reads 0x03011 in bits [31:12] and zero below, and writes to it are ignored. Control at 0x18 keeps bits [7:0]. Alarm at 0x14 keeps bits [16:0]. Trim at 0x20 keeps all 32 bits. Any other address reads zero.
- R9: A counter write in the same cycle as a tick_sec pulse takes precedence. The written value is kept and no flag is raised for that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_sec | input | 1 | One-cycle pulse per elapsed second |
| tick_half | input | 1 | One-cycle pulse midway between second pulses |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_periodic | output | 1 | Enabled boundary flags, OR-ed |
| irq_alarm | output | 1 | Alarm interrupt |
| wake_out | output | 1 | Alarm wake-up request |

## Verification
The bench builds the block with its default 6-bit address and the fixed field layout. Because the counter is writable, any point on the calendar can be preset. Each carry case can therefore be reached with a single tick, including the 32767-day wrap, which would otherwise take decades of simulated ticks. Alarm matching, flag clearing and write-versus-tick collisions are driven in exact cycles through the register port.

// File: rtl/rtc_daytime_core.sv
`timescale 1ns/1ps
module rtc_daytime_core #(
  parameter int          ADDR_W  = 6,
  parameter logic [19:0] ID_CODE = 20'h03011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_sec,
  input  logic              tick_half,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_periodic,
  output logic              irq_alarm,
  output logic              wake_out
);
  localparam int HMS_W = 17;
  localparam int DAY_W = 32 - HMS_W;
  localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_ALM  = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'('h1C);
  localparam logic [ADDR_W-1:0] A_TRIM = ADDR_W'('h20);

  logic [31:0]      cnt_q, trim_q;
  logic [HMS_W-1:0] alm_q;
  logic [7:0]       ctrl_q, sts_q;

  wire wr      = bus_sel & bus_wr;
  wire wr_cnt  = wr && bus_addr == A_CNT;
  wire wr_alm  = wr && bus_addr == A_ALM;
  wire wr_ctrl = wr && bus_addr == A_CTRL;
  wire wr_sts  = wr && bus_addr == A_STS;
  wire wr_trim = wr && bus_addr == A_TRIM;

  wire run  = ctrl_q[0];
  wire step = run & tick_sec & ~wr_cnt;
  wire half = run & tick_half;

  wire [5:0]       sec = cnt_q[5:0];
  wire [5:0]       mnt = cnt_q[11:6];
  wire [4:0]       hr  = cnt_q[16:12];
  wire [DAY_W-1:0] day = cnt_q[31:17];

  wire sec_top = sec >= 6'd59;
  wire mnt_top = mnt >= 6'd59;
  wire hr_top  = hr  >= 5'd23;
  wire c_mnt   = sec_top;
  wire c_hr    = c_mnt & mnt_top;
  wire c_day   = c_hr & hr_top;

  wire [5:0]       n_sec = sec_top ? 6'd0 : sec + 6'd1;
  wire [5:0]       n_mnt = c_mnt ? (mnt_top ? 6'd0 : mnt + 6'd1) : mnt;
  wire [4:0]       n_hr  = c_hr ? (hr_top ? 5'd0 : hr + 5'd1) : hr;
  wire [DAY_W-1:0] n_day = c_day ? day + 1'b1 : day;
  wire [HMS_W-1:0] n_hms = {n_hr, n_mnt, n_sec};

  wire [7:0] set_v = {half, step, step & c_mnt, step & c_hr, step & c_day,
                      step & (n_hms == alm_q), 2'b00};
  wire [7:0] clr_v = wr_sts ? (bus_wdata[7:0] & 8'hFC) : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      alm_q  <= '0;
      ctrl_q <= '0;
      sts_q  <= '0;
      trim_q <= '0;
    end else begin
      if (wr_cnt)       cnt_q <= bus_wdata;
      else if (step)    cnt_q <= {n_day, n_hms};
      if (wr_alm)  alm_q  <= bus_wdata[HMS_W-1:0];
      if (wr_ctrl) ctrl_q <= bus_wdata[7:0];
      if (wr_trim) trim_q <= bus_wdata;
      sts_q <= (sts_q & ~clr_v) | set_v;
    end
  end

  always_comb begin
    case (bus_addr)
      A_ID:    bus_rdata = {ID_CODE, 12'h000};
      A_CNT:   bus_rdata = cnt_q;
      A_ALM:   bus_rdata = {{(32-HMS_W){1'b0}}, alm_q};
      A_CTRL:  bus_rdata = {24'h0, ctrl_q};
      A_STS:   bus_rdata = {24'h0, sts_q};
      A_TRIM:  bus_rdata = trim_q;
      default: bus_rdata = '0;
    endcase
  end

  assign irq_periodic = |(sts_q[7:3] & ctrl_q[7:3]);
  assign irq_alarm    = sts_q[2] & ctrl_q[2];
  assign wake_out     = sts_q[2] & ctrl_q[1];
endmodule

// File: rtl/rtc_daytime_chk.sv
`timescale 1ns/1ps
module rtc_daytime_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic        tick_sec,
  input logic        tick_half,
  input logic        wr_cnt,
  input logic        wr_sts,
  input logic        clr_sec,
  input logic [31:0] cnt,
  input logic [16:0] alm,
  input logic        alm_flag,
  input logic        sec_flag,
  input logic        half_flag
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cnt) |=> $stable(cnt));

  p_sec_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick_sec && !wr_cnt) |=> (cnt[5:0] <= 6'd59));

  p_half_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick_half) |=> half_flag);

  p_alarm_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(alm_flag) && $stable(alm)) |-> (cnt[16:0] == alm));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && clr_sec && !(run && tick_sec && !wr_cnt)) |=> !sec_flag);
endmodule

bind rtc_daytime_core rtc_daytime_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(ctrl_q[0]), .tick_sec(tick_sec),
  .tick_half(tick_half), .wr_cnt(wr_cnt), .wr_sts(wr_sts),
  .clr_sec(bus_wdata[6]), .cnt(cnt_q), .alm(alm_q), .alm_flag(sts_q[2]),
  .sec_flag(sts_q[6]), .half_flag(sts_q[7])
);

// File: tb/sim_rtc_daytime_core.sv
`timescale 1ns/1ps
module sim_rtc_daytime_core;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0, tick_sec = 1'b0, tick_half = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_periodic, irq_alarm, wake_out;

  rtc_daytime_core u0 (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // {preset counter, ticks, expected counter, expected status}
  localparam logic [79:0] VEC [6] = '{
    {32'h0000_0000, 8'd1, 32'h0000_0001, 8'h40},
    {32'h0000_003B, 8'd1, 32'h0000_0040, 8'h60},
    {32'h0000_0EFB, 8'd1, 32'h0000_1000, 8'h70},
    {32'h000B_7EFB, 8'd1, 32'h000C_0000, 8'h78},
    {32'hFFFF_7EFB, 8'd1, 32'h0000_0000, 8'h78},
    {32'h0000_0010, 8'd3, 32'h0000_0013, 8'h40}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_sec = 1'b1;
      @(negedge clk); tick_sec = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog got hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(6'h10, d); chk("R1 counter", d, 0);
    rd(6'h14, d); chk("R1 alarm", d, 0);
    rd(6'h18, d); chk("R1 control", d, 0);
    rd(6'h1C, d); chk("R1 status", d, 0);
    rd(6'h20, d); chk("R1 trim", d, 0);
    chk("R1 outputs", {29'd0, irq_periodic, irq_alarm, wake_out}, 0);

    // vector table: R2 increment, R3 rollovers, R4 boundary flags
    wr(6'h14, 32'h0001_F000);
    foreach (VEC[i]) begin
      wr(6'h18, 32'h0);
      wr(6'h10, VEC[i][79:48]);
      wr(6'h1C, 32'hFF);
      wr(6'h18, 32'h1);
      ticks(int'(VEC[i][47:40]));
      rd(6'h10, d); chk($sformatf("R2/R3 vector %0d counter", i), d, VEC[i][39:8]);
      rd(6'h1C, d); chk($sformatf("R4 vector %0d status", i), d, {24'h0, VEC[i][7:0]});
    end

    // R2 disabled counting
    wr(6'h18, 32'h0); wr(6'h10, 32'h5); wr(6'h1C, 32'hFF);
    ticks(3);
    @(negedge clk); tick_half = 1'b1; @(negedge clk); tick_half = 1'b0;
    rd(6'h10, d); chk("R2 disabled counter", d, 32'h5);
    rd(6'h1C, d); chk("R2 disabled status", d, 0);

    // R4 half-second flag
    wr(6'h18, 32'h1);
    @(negedge clk); tick_half = 1'b1; @(negedge clk); tick_half = 1'b0;
    rd(6'h1C, d); chk("R4 half flag", d, 32'h80);
    rd(6'h10, d); chk("R4 half no count", d, 32'h5);

    // R5 alarm match ignoring day, R7 gating
    wr(6'h18, 32'h0); wr(6'h14, 32'h0000_1041);
    wr(6'h10, 32'h0006_1040); wr(6'h1C, 32'hFF); wr(6'h18, 32'h1);
    ticks(1);
    rd(6'h1C, d); chk("R5 alarm flag", d, 32'h44);
    chk("R7 alarm masked", {30'd0, irq_alarm, wake_out}, 0);
    wr(6'h18, 32'h3);
    chk("R7 wake only", {30'd0, irq_alarm, wake_out}, 32'h1);
    wr(6'h18, 32'h5);
    chk("R7 irq only", {30'd0, irq_alarm, wake_out}, 32'h2);
    wr(6'h18, 32'h9);
    chk("R7 periodic masked", {31'd0, irq_periodic}, 0);
    wr(6'h18, 32'h41);
    chk("R7 periodic on", {31'd0, irq_periodic}, 1);

    // R6 clear semantics
    wr(6'h1C, 32'hFF); ticks(1);
    wr(6'h1C, 32'h0);
    rd(6'h1C, d); chk("R6 write zero", d, 32'h40);
    wr(6'h1C, 32'hBF);
    rd(6'h1C, d); chk("R6 other bits", d, 32'h40);
    wr(6'h1C, 32'h40);
    rd(6'h1C, d); chk("R6 clear", d, 0);
    @(negedge clk);
    tick_sec = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h1C; bus_wdata = 32'h40;
    @(negedge clk);
    tick_sec = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    rd(6'h1C, d); chk("R6 set wins", d, 32'h40);

    // R9 counter write beats tick
    wr(6'h1C, 32'hFF);
    @(negedge clk);
    tick_sec = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h10; bus_wdata = 32'h123;
    @(negedge clk);
    tick_sec = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    rd(6'h10, d); chk("R9 written value", d, 32'h123);
    rd(6'h1C, d); chk("R9 no flag", d, 0);

    // R8 register map
    rd(6'h00, d); chk("R8 id", d, 32'h0301_1000);
    wr(6'h00, 32'h0); rd(6'h00, d); chk("R8 id read-only", d, 32'h0301_1000);
    wr(6'h18, 32'hFFFF_FFFF); rd(6'h18, d); chk("R8 control width", d, 32'hFF);
    wr(6'h18, 32'h0);
    wr(6'h14, 32'hFFFF_FFFF); rd(6'h14, d); chk("R8 alarm width", d, 32'h1_FFFF);
    wr(6'h20, 32'hA5A5_5A5A); rd(6'h20, d); chk("R8 trim", d, 32'hA5A5_5A5A);
    rd(6'h04, d); chk("R8 unmapped 04", d, 0);
    rd(6'h24, d); chk("R8 unmapped 24", d, 0);
    rd(6'h11, d); chk("R8 misaligned", d, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule